// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a simple memory and arbitrates atomic read-modify-write sequences issued by several hardware contexts. A context opens a reservation with a load-locked request. The block stores the address of the enclosing 16-byte line in a slot owned by that context. A later store-conditional from the same context writes only if that reservation is still intact. Any write to a reserved line breaks the reservation for every context that holds it, whether the write comes from a plain store or from a store-conditional that succeeds.

Requests enter on a valid/ready channel. Each request is decided in the cycle it is presented: the response channel carries a status bit, and a memory write-enable comes with it together with the unmasked address and data. The block holds no buffering of its own. Back-pressure therefore passes straight through: `req_ready` follows `rsp_ready`. A request takes effect on the reservation table, and can write memory, only in a cycle where both `req_valid` and `rsp_ready` are high. Outside such a cycle the response outputs are only a preview. A `flush` pin empties the table at a context switch or during a drain.

Top module: `llsc_monitor`

## Requirements
- R1: After a synchronous reset no reservation is held, so a store-conditional from any context fails.
- R2: Reservations cover 16-byte lines. The low 4 address bits are ignored when a reservation is recorded and when it is compared, so a store-conditional at any offset within the reserved line matches.
- R3: A load-locked (op code 2'b01) records the line for the requesting context. A later load-locked from the same context replaces that context's earlier line.
- R4: A store-conditional (op code 2'b11) succeeds only when the requesting context holds a reservation on the same line. On success `rsp_ok`=1 and `mem_we`=1 in that same cycle.
- R5: A failed store-conditional returns `rsp_ok`=0, keeps `mem_we` low and leaves every reservation unchanged.
- R6: A plain store (op code 2'b10) always writes with `rsp_ok`=1. It clears the reservation of every context, including the requester, whose line matches its address.
- R7: A successful store-conditional clears every reservation on its line, including the requester's own.
- R8: A plain load (op code 2'b00) and a load-locked return `rsp_ok`=1 and `mem_we`=0. A plain load leaves the table unchanged.
- R9: With `flush` high the table is empty from the next cycle on. Flush takes priority over a load-locked accepted in the same cycle. A request accepted in a flush cycle is decided from the table as it was before the flush.
- R10: `req_ready` equals `rsp_ready` and `rsp_valid` equals `req_valid`. While `rsp_ready` is low, `mem_we` stays low and a presented request does not change the table.
- R11: `mem_addr` and `mem_wdata` carry the full, unmasked request address and the request data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Clear all reservations |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 00 load, 01 load-locked, 10 store, 11 store-conditional |
| req_addr | input | AW | Byte address |
| req_ctx | input | CW | Requesting context index |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer can take the response |
| rsp_ok | output | 1 | 1 = success, 0 = store-conditional failed |
| mem_we | output | 1 | Memory write strobe, high only on an accepted write |
| mem_addr | output | AW | Address to memory |
| mem_wdata | output | DW | Data to memory |

## Verification
If a slot held a stale line or the wrong owner, the block would show it on the very next store-conditional that probes that line. That request would return the wrong `rsp_ok` and a wrong `mem_we` in the same cycle. A missed clear would show up the same way, one request later. The bench therefore keeps its own model of the table. It drives long mixed sequences over four contexts and a handful of lines, with stalls and flushes mixed in. Every response is compared in the cycle it appears, so any slot that diverges from the model is caught at its next probe.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_LL    = 2'b01,
    OP_STORE = 2'b10,
    OP_SC    = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_resv_slot.sv
// One reservation slot, owned by a single context.
module llsc_resv_slot #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [LW-1:0] line_in,
  output logic          vld,
  output logic          hit
);
  logic [LW-1:0] line_q;

  assign hit = vld && (line_q == line_in);

  // Clearing (reset, flush, matching write) wins over setting.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= 1'b0;
    end else if (clr_en && hit) begin
      vld <= 1'b0;
    end else if (set_en) begin
      vld    <= 1'b1;
      line_q <= line_in;
    end
  end

  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !vld);
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> !vld);
  a_r3_set_records: assert property (@(posedge clk) disable iff (rst)
    (set_en && !flush && !(clr_en && hit)) |=> (vld && line_q == $past(line_in)));
  a_r6_hit_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_en && hit) |=> !vld);
endmodule

// File: rtl/llsc_decide.sv
// Combinational verdict for one request.
module llsc_decide
  import llsc_pkg::*;
(
  input  llsc_op_e op,
  input  logic     fire,
  input  logic     own_hit,
  output logic     ok,
  output logic     wr_fire,
  output logic     ll_fire
);
  logic is_wr;

  always_comb begin
    ok    = 1'b1;
    is_wr = 1'b0;
    unique case (op)
      OP_STORE: is_wr = 1'b1;
      OP_SC: begin
        ok    = own_hit;
        is_wr = own_hit;
      end
      default: ;
    endcase
  end

  assign wr_fire = fire && is_wr;
  assign ll_fire = fire && (op == OP_LL);

  always_comb begin
    a_r4_write_is_ok: assert (!wr_fire || ok);
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NCTX      = 4,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int GRAN_BITS = 4,
  localparam int CW       = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int LW       = AW - GRAN_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_ctx,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_ok,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  llsc_op_e        op;
  logic [LW-1:0]   line;
  logic            fire, own_hit, wr_fire, ll_fire;
  logic [NCTX-1:0] ctx_sel, slot_vld, slot_hit;

  assign op        = llsc_op_e'(req_op);
  assign line      = req_addr[AW-1:GRAN_BITS];
  assign fire      = req_valid && rsp_ready;
  assign req_ready = rsp_ready;
  assign rsp_valid = req_valid;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign mem_we    = wr_fire;
  assign own_hit   = |(slot_hit & ctx_sel);

  for (genvar i = 0; i < NCTX; i++) begin : g_slot
    assign ctx_sel[i] = (req_ctx == CW'(i));
    llsc_resv_slot #(.LW(LW)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .set_en  (ll_fire && ctx_sel[i]),
      .clr_en  (wr_fire),
      .line_in (line),
      .vld     (slot_vld[i]),
      .hit     (slot_hit[i])
    );
  end

  llsc_decide u_decide (
    .op      (op),
    .fire    (fire),
    .own_hit (own_hit),
    .ok      (rsp_ok),
    .wr_fire (wr_fire),
    .ll_fire (ll_fire)
  );

  a_r10_stall_no_write: assert property (@(posedge clk) disable iff (rst)
    !rsp_ready |-> !mem_we);
  a_r4_sc_needs_own: assert property (@(posedge clk) disable iff (rst)
    (mem_we && op == OP_SC) |-> |(slot_vld & ctx_sel));
  a_r5_failed_sc_keeps: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_SC && !rsp_ok && !flush) |=> (slot_vld == $past(slot_vld)));
  a_r8_load_keeps: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_LOAD && !flush) |=> (slot_vld == $past(slot_vld)));
endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int NCTX = 4, AW = 16, DW = 32, GB = 4, CW = 2, LW = AW - GB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, flush, req_valid, req_ready, rsp_valid, rsp_ready, rsp_ok, mem_we;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr, mem_addr;
  logic [CW-1:0] req_ctx;
  logic [DW-1:0] req_wdata, mem_wdata;

  llsc_monitor #(.NCTX(NCTX), .AW(AW), .DW(DW), .GRAN_BITS(GB)) u_llsc_monitor (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_ctx(req_ctx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  int checks = 0, fails = 0;
  logic          m_vld [NCTX];
  logic [LW-1:0] m_line[NCTX];

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one request at the falling edge, check outputs, then update the model.
  task automatic step(input string tag, input logic [1:0] op, input logic [AW-1:0] addr,
                      input logic [CW-1:0] ctx, input logic rdy = 1'b1,
                      input logic fl = 1'b0, input logic vreq = 1'b1);
    logic [LW-1:0] ln;
    logic own, e_ok, e_we, fire;
    @(negedge clk);
    req_valid = vreq; req_op = op; req_addr = addr; req_ctx = ctx;
    req_wdata = {16'hC3A5, addr}; rsp_ready = rdy; flush = fl;
    #1;
    ln   = addr[AW-1:GB];
    own  = m_vld[ctx] && (m_line[ctx] == ln);
    fire = vreq && rdy;
    e_ok = !(op == 2'b11 && !own);
    e_we = fire && (op == 2'b10 || (op == 2'b11 && own));
    chk(tag, "req_ready", 64'(req_ready), 64'(rdy));
    chk(tag, "rsp_valid", 64'(rsp_valid), 64'(vreq));
    chk(tag, "mem_we", 64'(mem_we), 64'(e_we));
    if (vreq) begin
      chk(tag, "rsp_ok", 64'(rsp_ok), 64'(e_ok));
      chk(tag, "mem_addr", 64'(mem_addr), 64'(addr));
      chk(tag, "mem_wdata", 64'(mem_wdata), 64'({16'hC3A5, addr}));
    end
    if (fl) begin
      for (int i = 0; i < NCTX; i++) m_vld[i] = 1'b0;
    end else if (fire) begin
      if (e_we)
        for (int i = 0; i < NCTX; i++)
          if (m_vld[i] && m_line[i] == ln) m_vld[i] = 1'b0;
      if (op == 2'b01) begin
        m_vld[ctx] = 1'b1;
        m_line[ctx] = ln;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; flush = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0;
    req_ctx = '0; req_wdata = '0; rsp_ready = 1'b1;
    for (int i = 0; i < NCTX; i++) begin m_vld[i] = 1'b0; m_line[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: empty table after reset, every context's SC fails
    for (int c = 0; c < NCTX; c++) step("R1", 2'b11, 16'h0040, CW'(c));
    // R2: offsets inside a line match
    step("R3", 2'b01, 16'h0123, 2'd0);
    step("R2", 2'b11, 16'h012F, 2'd0);
    // R3: a new LL replaces the old line of the same context
    step("R3", 2'b01, 16'h0200, 2'd1);
    step("R3", 2'b01, 16'h0300, 2'd1);
    step("R3", 2'b11, 16'h0200, 2'd1);
    step("R4", 2'b11, 16'h0304, 2'd1);
    // R4: another context cannot use a foreign reservation
    step("R3", 2'b01, 16'h0500, 2'd2);
    step("R4", 2'b11, 16'h0500, 2'd3);
    step("R5", 2'b11, 16'h0500, 2'd2);
    // R6: a plain store clears all matching slots, own and foreign
    step("R3", 2'b01, 16'h0600, 2'd0);
    step("R3", 2'b01, 16'h0608, 2'd1);
    step("R6", 2'b10, 16'h060C, 2'd1);
    step("R6", 2'b11, 16'h0600, 2'd0);
    step("R6", 2'b11, 16'h0600, 2'd1);
    // R7: a successful SC clears the other holders too
    step("R3", 2'b01, 16'h0700, 2'd2);
    step("R3", 2'b01, 16'h0700, 2'd3);
    step("R7", 2'b11, 16'h0700, 2'd2);
    step("R7", 2'b11, 16'h0700, 2'd3);
    // R8: a plain load leaves reservations intact
    step("R3", 2'b01, 16'h0800, 2'd0);
    step("R8", 2'b00, 16'h0800, 2'd1);
    step("R8", 2'b11, 16'h0800, 2'd0);
    // R9: flush wins over a same-cycle LL, and the coincident SC sees the old table
    step("R3", 2'b01, 16'h0900, 2'd1);
    step("R9", 2'b11, 16'h0900, 2'd1, 1'b1, 1'b1);
    step("R3", 2'b01, 16'h0A00, 2'd2);
    step("R9", 2'b01, 16'h0B00, 2'd3, 1'b1, 1'b1);
    step("R9", 2'b11, 16'h0A00, 2'd2);
    step("R9", 2'b11, 16'h0B00, 2'd3);
    // R10: a stalled request neither writes nor reserves
    step("R10", 2'b01, 16'h0C00, 2'd0, 1'b0);
    step("R10", 2'b11, 16'h0C00, 2'd0);
    step("R3", 2'b01, 16'h0C00, 2'd0);
    step("R10", 2'b11, 16'h0C00, 2'd0, 1'b0);
    step("R10", 2'b10, 16'h0C00, 2'd1, 1'b0);
    step("R11", 2'b11, 16'h0C0B, 2'd0);

    // Sweep: every op, context and flush/stall mix over four lines
    r = 32'h1BAD_5EED;
    for (int n = 0; n < 6000; n++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      step("R4/R6/R7 sweep", r[1:0], AW'({r[5:4], r[9:6]}), r[3:2],
           r[12:10] != 3'd0, r[17:13] == 5'd0, r[20:18] != 3'd0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule